// File: doc/BRIEF.md
# Function Unit Dependency Matrix

This block tracks ordering hazards between the function units of an out-of-order core. It is a square bit array with one row and one column per function unit. Unit identities are one-hot vectors, not binary tags, so nothing in the array is compared or looked up by content. Each row records which other units its owner must wait for. The set bits across all rows form a directed acyclic graph of waits.

Two independent planes are kept. The read-wait plane marks units whose results are still pending, so the row owner may not read its operands yet. The write-wait plane marks units that have not yet read their operands, so the row owner may not write its result yet.

When a unit issues, its row in both planes is loaded with vectors supplied by the issue logic. When a unit has written its result, its column in the read-wait plane is wiped in every row. When a unit has read its operands, its column in the write-wait plane is wiped in every row. Each unit's read-ready and write-ready outputs are a plain NOR across its row in the matching plane.

Top module: `fu_dep_matrix`

## Requirements
- R1: After reset every bit of both planes is clear, so `rd_ready` and `wr_ready` are all ones.
- R2: An issue with one-hot `issue_fu` selecting unit k loads row k of the read-wait plane with `issue_raw`. From the next cycle `rd_ready[k]` is 0 exactly when that loaded row is non-zero.
- R3: The same issue loads row k of the write-wait plane with `issue_war`. From the next cycle `wr_ready[k]` is 0 exactly when that loaded row is non-zero.
- R4: Bit k of either vector is never stored in row k. An issue whose only set bit is the unit's own index leaves that unit ready.
- R5: A set bit j of `wr_done` clears column j of the read-wait plane in every row at the same clock edge. It leaves the write-wait plane unchanged.
- R6: A set bit j of `rd_done` clears column j of the write-wait plane in every row at the same clock edge. It leaves the read-wait plane unchanged.
- R7: When an issue and a clear address the same bit in one cycle, the bit ends up clear.
- R8: An issue is taken only when `issue_en` is 1 and `issue_fu` has exactly one bit set. Otherwise no row changes.
- R9: A row that is neither loaded nor hit by a clear keeps its contents.
- R10: A new issue into a row replaces the row's previous contents; the old and new vectors are not merged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_en | input | 1 | Issue strobe |
| issue_fu | input | N_FU | One-hot index of the issuing unit |
| issue_raw | input | N_FU | Units whose results the issuing unit must wait for before reading |
| issue_war | input | N_FU | Units whose operand reads must finish before the issuing unit writes |
| wr_done | input | N_FU | Units that wrote their result this cycle |
| rd_done | input | N_FU | Units that read their operands this cycle |
| rd_ready | output | N_FU | Per-unit: no pending read-wait bit |
| wr_ready | output | N_FU | Per-unit: no pending write-wait bit |

## Verification
The bench goes after the cases where a single bit is hit by two events in one cycle:
- An issue landing on a column being cleared. A design that lets the load win would leave a unit stalled forever on a result that has already been written.
- An issue whose vector names the issuing unit itself. A design that stores the diagonal bit would deadlock that unit.
- An issue with a zero or multi-bit unit index. A design that accepts it would corrupt several rows at once.
- Cross-plane isolation, where a result write must not release a write wait. A design that mixes the planes would release hazards early.
- Re-issue into a busy row. A merging design would keep stale waits and hold the unit back after its real producer finished.

// File: rtl/fu_dep_pkg.sv
package fu_dep_pkg;

  // Widest unit count supported by the helper functions.
  localparam int FU_MAX = 64;

  typedef logic [FU_MAX-1:0] fu_vec_t;

  // Number of set bits in a (zero-extended) unit vector.
  function automatic int unsigned fu_popcount(fu_vec_t v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < FU_MAX; i++) begin
      n += int'(v[i]);
    end
    return n;
  endfunction

  // True when exactly one unit is named.
  function automatic logic fu_single(fu_vec_t v);
    return fu_popcount(v) == 1;
  endfunction

  // True when no unit is named: the readiness NOR.
  function automatic logic fu_none(fu_vec_t v);
    return v == '0;
  endfunction

endpackage

// File: rtl/fu_dep_issue_dec.sv
module fu_dep_issue_dec
  import fu_dep_pkg::*;
#(
  parameter int N_FU = 4
) (
  input  logic            issue_en,
  input  logic [N_FU-1:0] issue_fu,
  output logic            issue_ok,
  output logic [N_FU-1:0] row_load
);

  // Accept only a strobe with a strictly one-hot unit index.
  assign issue_ok = issue_en && fu_single(fu_vec_t'(issue_fu));
  assign row_load = issue_ok ? issue_fu : '0;

endmodule

// File: rtl/fu_dep_plane.sv
module fu_dep_plane #(
  parameter int N_FU = 4,
  localparam int BITS = N_FU * N_FU
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_FU-1:0] row_load,
  input  logic [N_FU-1:0] load_vec,
  input  logic [N_FU-1:0] col_clear,
  output logic [BITS-1:0] cells
);

  // Next value of one row: load (minus the diagonal), then the clear wins.
  function automatic logic [N_FU-1:0] row_next(
    input logic [N_FU-1:0] cur,
    input logic            load,
    input logic [N_FU-1:0] vec,
    input logic [N_FU-1:0] self_bit,
    input logic [N_FU-1:0] clr
  );
    logic [N_FU-1:0] base;
    base = load ? (vec & ~self_bit) : cur;
    return base & ~clr;
  endfunction

  for (genvar r = 0; r < N_FU; r++) begin : g_row
    localparam logic [N_FU-1:0] SELF = N_FU'(1) << r;
    logic [N_FU-1:0] row_q;
    logic [N_FU-1:0] row_d;

    assign row_d = row_next(row_q, row_load[r], load_vec, SELF, col_clear);

    always_ff @(posedge clk) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_d;
    end

    assign cells[r*N_FU +: N_FU] = row_q;
  end

endmodule

// File: rtl/fu_dep_ready.sv
module fu_dep_ready
  import fu_dep_pkg::*;
#(
  parameter int N_FU = 4,
  localparam int BITS = N_FU * N_FU
) (
  input  logic [BITS-1:0] cells,
  output logic [N_FU-1:0] ready
);

  for (genvar r = 0; r < N_FU; r++) begin : g_nor
    assign ready[r] = fu_none(fu_vec_t'(cells[r*N_FU +: N_FU]));
  end

endmodule

// File: rtl/fu_dep_matrix.sv
module fu_dep_matrix #(
  parameter int N_FU = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_en,
  input  logic [N_FU-1:0] issue_fu,
  input  logic [N_FU-1:0] issue_raw,
  input  logic [N_FU-1:0] issue_war,
  input  logic [N_FU-1:0] wr_done,
  input  logic [N_FU-1:0] rd_done,
  output logic [N_FU-1:0] rd_ready,
  output logic [N_FU-1:0] wr_ready
);

  localparam int BITS = N_FU * N_FU;

  // Named internal events, visible to the bound checker.
  logic            issue_ok;
  logic [N_FU-1:0] issue_load;
  logic [BITS-1:0] raw_cells;
  logic [BITS-1:0] war_cells;

  fu_dep_issue_dec #(.N_FU(N_FU)) u_dec (
    .issue_en (issue_en),
    .issue_fu (issue_fu),
    .issue_ok (issue_ok),
    .row_load (issue_load)
  );

  // Read-wait plane: column j released when unit j writes its result.
  fu_dep_plane #(.N_FU(N_FU)) u_raw_plane (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_load  (issue_load),
    .load_vec  (issue_raw),
    .col_clear (wr_done),
    .cells     (raw_cells)
  );

  // Write-wait plane: column j released when unit j reads its operands.
  fu_dep_plane #(.N_FU(N_FU)) u_war_plane (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_load  (issue_load),
    .load_vec  (issue_war),
    .col_clear (rd_done),
    .cells     (war_cells)
  );

  fu_dep_ready #(.N_FU(N_FU)) u_rd_nor (
    .cells (raw_cells),
    .ready (rd_ready)
  );

  fu_dep_ready #(.N_FU(N_FU)) u_wr_nor (
    .cells (war_cells),
    .ready (wr_ready)
  );

endmodule

// File: rtl/fu_dep_matrix_chk.sv
module fu_dep_matrix_chk #(
  parameter int N_FU = 4,
  localparam int BITS = N_FU * N_FU
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_ok,
  input logic [N_FU-1:0] issue_load,
  input logic [N_FU-1:0] issue_raw,
  input logic [N_FU-1:0] issue_war,
  input logic [N_FU-1:0] wr_done,
  input logic [N_FU-1:0] rd_done,
  input logic [BITS-1:0] raw_cells,
  input logic [BITS-1:0] war_cells
);

  // Any set cell inside the masked columns, across all rows.
  function automatic logic col_any(input logic [BITS-1:0] c,
                                   input logic [N_FU-1:0] m);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < N_FU; r++) begin
      hit |= |(c[r*N_FU +: N_FU] & m);
    end
    return hit;
  endfunction

  // OR of the rows picked by a one-hot selector.
  function automatic logic [N_FU-1:0] row_pick(input logic [BITS-1:0] c,
                                               input logic [N_FU-1:0] s);
    logic [N_FU-1:0] v;
    v = '0;
    for (int r = 0; r < N_FU; r++) begin
      if (s[r]) v |= c[r*N_FU +: N_FU];
    end
    return v;
  endfunction

  p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_load) && (issue_ok == (issue_load != '0)));

  p_raw_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && wr_done == '0) |=>
      row_pick(raw_cells, $past(issue_load)) == ($past(issue_raw) & ~$past(issue_load)));

  p_war_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_ok && rd_done == '0) |=>
      row_pick(war_cells, $past(issue_load)) == ($past(issue_war) & ~$past(issue_load)));

  p_raw_col_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done != '0) |=> !col_any(raw_cells, $past(wr_done)));

  p_war_col_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done != '0) |=> !col_any(war_cells, $past(rd_done)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_ok && wr_done == '0 && rd_done == '0) |=>
      ($stable(raw_cells) && $stable(war_cells)));

endmodule

bind fu_dep_matrix fu_dep_matrix_chk #(.N_FU(N_FU)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_ok   (issue_ok),
  .issue_load (issue_load),
  .issue_raw  (issue_raw),
  .issue_war  (issue_war),
  .wr_done    (wr_done),
  .rd_done    (rd_done),
  .raw_cells  (raw_cells),
  .war_cells  (war_cells)
);

// File: tb/test_fu_dep_matrix.sv
module test_fu_dep_matrix;

  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_en = 1'b0;
  logic [N-1:0] issue_fu = '0;
  logic [N-1:0] issue_raw = '0;
  logic [N-1:0] issue_war = '0;
  logic [N-1:0] wr_done = '0;
  logic [N-1:0] rd_done = '0;
  logic [N-1:0] rd_ready;
  logic [N-1:0] wr_ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model: one wait vector per unit and plane.
  logic [N-1:0] m_raw [N];
  logic [N-1:0] m_war [N];

  logic [2*N-1:0] exp_q [$];
  string          tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fu_dep_matrix #(.N_FU(N)) i_fu_dep_matrix (
    .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .issue_fu(issue_fu),
    .issue_raw(issue_raw), .issue_war(issue_war), .wr_done(wr_done),
    .rd_done(rd_done), .rd_ready(rd_ready), .wr_ready(wr_ready)
  );

  function automatic int bits_set(logic [N-1:0] v);
    int n = 0;
    for (int i = 0; i < N; i++) if (v[i]) n++;
    return n;
  endfunction

  // Driver: apply one cycle of stimulus, advance the model, queue expectation.
  task automatic step(input logic en, input logic [N-1:0] fu,
                      input logic [N-1:0] raw, input logic [N-1:0] war,
                      input logic [N-1:0] wd, input logic [N-1:0] rdn,
                      input string tag);
    logic [N-1:0] er, ew;
    @(negedge clk);
    issue_en = en; issue_fu = fu; issue_raw = raw; issue_war = war;
    wr_done = wd; rd_done = rdn;
    for (int u = 0; u < N; u++) begin
      if (en && bits_set(fu) == 1 && fu[u]) begin
        m_raw[u] = raw;
        m_war[u] = war;
        m_raw[u][u] = 1'b0;
        m_war[u][u] = 1'b0;
      end
      m_raw[u] = m_raw[u] & ~wd;
      m_war[u] = m_war[u] & ~rdn;
      er[u] = (m_raw[u] == '0);
      ew[u] = (m_war[u] == '0);
    end
    exp_q.push_back({er, ew});
    tag_q.push_back(tag);
    @(posedge clk);
    #1;
    issue_en = 1'b0; issue_fu = '0; issue_raw = '0; issue_war = '0;
    wr_done = '0; rd_done = '0;
  endtask

  // Monitor: compare after every edge that has an expectation pending.
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [2*N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({rd_ready, wr_ready} !== e) begin
        errors++;
        $display("FAIL %s: rd_ready=%b wr_ready=%b expected rd_ready=%b wr_ready=%b",
                 t, rd_ready, wr_ready, e[2*N-1:N], e[N-1:0]);
      end
    end
  end

  initial begin
    for (int u = 0; u < N; u++) begin m_raw[u] = '0; m_war[u] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R1 reset state");
    step(1, 4'b0001, 4'b0010, 4'b0000, 4'b0000, 4'b0000, "R2 read wait loaded");
    step(1, 4'b0010, 4'b0000, 4'b0100, 4'b0000, 4'b0000, "R3 write wait loaded");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R9 idle hold");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, "R5 result clears read column");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0000, "R5 result leaves write plane");
    step(1, 4'b0100, 4'b0100, 4'b0100, 4'b0000, 4'b0000, "R4 diagonal dropped");
    step(1, 4'b1000, 4'b1001, 4'b0001, 4'b0000, 4'b0001, "R7 clear beats issue");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0100, "R6 read clears write column");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0001, "R6 read leaves read plane");
    step(1, 4'b0011, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R8 multi-hot index ignored");
    step(1, 4'b0000, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R8 zero index ignored");
    step(0, 4'b0001, 4'b1111, 4'b1111, 4'b0000, 4'b0000, "R8 strobe low ignored");
    step(1, 4'b1000, 4'b0100, 4'b0000, 4'b0000, 4'b0000, "R10 reissue replaces");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000, "R10 old wait gone");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0100, 4'b0000, "R10 new wait released");
    step(1, 4'b0010, 4'b1000, 4'b1000, 4'b0000, 4'b0000, "R2 second row");
    step(1, 4'b0100, 4'b1000, 4'b1000, 4'b0000, 4'b0000, "R3 third row");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b1000, 4'b0000, "R5 column in all rows");
    step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1000, "R6 column in all rows");
    step(1, 4'b0001, 4'b0010, 4'b0010, 4'b0010, 4'b0000, "R7 result same cycle as issue");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule